// File: doc/BRIEF.md
# Serial Link Power-Up Sequencer

This block is the control state machine that takes a current-mode serial display link from the OFF phase to streaming and back again. It runs on a reference clock. It receives a one-cycle pulse for every observed pixel-clock edge, and it counts the start-up phases in those pulses, so every interval is an exact number of pixel-clock cycles. The block drives no analog lines. It tells the line drivers what to do: the clock line is either off, held at logic low (the higher current), held at logic high (the lower current), or toggling. It also selects which data lines are active and enables the bias block.

A start-up runs through a fixed series of phases: a bias warm-up with no line current, a long low pulse on the clock line, a short high pulse, a short low pulse, and a hold-off that keeps the clock line low while the PLL settles. Streaming starts only after the hold-off has run out and the PLL reports lock. The link drops to OFF in two cases. One is the active-low power-down input. The other is the absence of pixel-clock pulses for a set number of reference cycles. When the pixel clock comes back, the whole sequence runs again. The lane count is sampled once, when a start-up begins.

Top module: `link_seq`

## Requirements
- R1: After reset, and at any time the link is OFF, `mc_drive` is 0 (no current), `md_en` is 0, `bias_en` is 0 and `stream_valid` is 0.
- R2: The link leaves OFF only when `pd_n` is high and the pixel clock is running, meaning a `pix_tick` has been seen within the last `STOP_LIMIT` reference cycles. The first cycle after OFF shows `bias_en` = 1.
- R3: The bias phase shows `bias_en` = 1 with `mc_drive` = 0 and lasts exactly `BIAS_TICKS` (200) pixel ticks. The tick on which the phase is entered does not count.
- R4: Next, `mc_drive` = 1 (logic low) for exactly `LOW1_TICKS` (200) ticks.
- R5: Next, `mc_drive` = 2 (logic high) for exactly `HIGH_TICKS` (20) ticks.
- R6: Next, `mc_drive` = 1 for `LOW2_TICKS` (8) ticks. It then stays 1 through a hold-off of `HOLD_TICKS` (600) ticks, and `stream_valid` stays 0 throughout.
- R7: When the hold-off has expired, streaming begins on the first cycle in which `pll_locked` is high. Until then the link stays in hold-off with `mc_drive` = 1.
- R8: While streaming, `mc_drive` = 3 (toggling) and `stream_valid` = 1. `md_en` is 3'b011 for two data lanes (`lane3_cfg` = 0) and 3'b111 for three lanes (`lane3_cfg` = 1).
- R9: `lane3_cfg` is captured on the cycle the link leaves OFF. Changes after that have no effect on `md_en` until the next start-up.
- R10: `pd_n` low forces the link to OFF on the next clock edge from any phase, and the captured lane setting is cleared.
- R11: If no `pix_tick` arrives for more than `STOP_LIMIT` (16) consecutive reference cycles, the link goes to OFF. Later ticks restart the sequence from the bias phase.
- R12: Phase counting advances only on `pix_tick`. Reference cycles without a tick leave the current phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down control: low forces OFF, high allows start-up |
| pix_tick | input | 1 | One-cycle pulse per observed pixel-clock edge |
| lane3_cfg | input | 1 | Lane count: 0 = two data lanes, 1 = three data lanes |
| pll_locked | input | 1 | PLL lock status |
| mc_drive | output | 2 | Clock-line drive: 0 off, 1 logic low, 2 logic high, 3 toggling |
| md_en | output | 3 | Per-lane data-line enable |
| bias_en | output | 1 | Bias block enable |
| stream_valid | output | 1 | Link is streaming pixel data |

## Verification
The assertions check on every cycle that an OFF link drives no current and that power-down or a stopped pixel clock reaches OFF one edge later. They also check that no phase changes without a finished count, that streaming only follows a low clock line and a locked PLL, and that the lane enables stay stable while streaming. Exact phase lengths in ticks, the effect of tick spacing, and lane capture across a later configuration change can only be shown by the bench. Its scenarios do this by comparing against a tick-counting model at several tick spacings and after each exit path.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  localparam int MAX_LANES = 3;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_BIAS     = 3'd1,
    ST_MC_LOW1  = 3'd2,
    ST_MC_HIGH  = 3'd3,
    ST_MC_LOW2  = 3'd4,
    ST_PLL_WAIT = 3'd5,
    ST_STREAM   = 3'd6
  } link_st_e;

  typedef enum logic [1:0] {
    MC_OFF    = 2'd0,
    MC_LOW    = 2'd1,
    MC_HIGH   = 2'd2,
    MC_TOGGLE = 2'd3
  } mc_drive_e;

  // successor of each counted phase; other states map to themselves
  function automatic link_st_e after_phase(input link_st_e s);
    case (s)
      ST_BIAS:    return ST_MC_LOW1;
      ST_MC_LOW1: return ST_MC_HIGH;
      ST_MC_HIGH: return ST_MC_LOW2;
      ST_MC_LOW2: return ST_PLL_WAIT;
      default:    return s;
    endcase
  endfunction

  function automatic mc_drive_e mc_for_state(input link_st_e s);
    case (s)
      ST_MC_LOW1, ST_MC_LOW2, ST_PLL_WAIT: return MC_LOW;
      ST_MC_HIGH:                          return MC_HIGH;
      ST_STREAM:                           return MC_TOGGLE;
      default:                             return MC_OFF;
    endcase
  endfunction

  // all lanes for the wide setting, top lane dropped otherwise
  function automatic logic [MAX_LANES-1:0] lane_mask(input logic three);
    logic [MAX_LANES-1:0] m;
    m = '1;
    if (!three) m[MAX_LANES-1] = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/link_clk_monitor.sv
module link_clk_monitor #(
  parameter int STOP_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_tick,
  output logic clk_stopped
);
  localparam int IDLE_W = $clog2(STOP_LIMIT + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(STOP_LIMIT);

  logic [IDLE_W-1:0] idle_q;

  // saturating count of reference cycles since the last pixel tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idle_q <= IDLE_MAX;
    else if (pix_tick)         idle_q <= '0;
    else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
  end

  assign clk_stopped = (idle_q == IDLE_MAX);
endmodule

// File: rtl/link_phase_fsm.sv
module link_phase_fsm
  import link_seq_pkg::*;
#(
  parameter int BIAS_TICKS = 200,
  parameter int LOW1_TICKS = 200,
  parameter int HIGH_TICKS = 20,
  parameter int LOW2_TICKS = 8,
  parameter int HOLD_TICKS = 600
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pd_n,
  input  logic     clk_stopped,
  input  logic     pix_tick,
  input  logic     pll_locked,
  output link_st_e state_q,
  output logic     phase_done,
  output logic     start_evt
);
  localparam int MAX_A   = (BIAS_TICKS > LOW1_TICKS) ? BIAS_TICKS : LOW1_TICKS;
  localparam int MAX_B   = (HIGH_TICKS > LOW2_TICKS) ? HIGH_TICKS : LOW2_TICKS;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LEN = (MAX_AB > HOLD_TICKS) ? MAX_AB : HOLD_TICKS;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  function automatic logic [CNT_W-1:0] phase_len(input link_st_e s);
    case (s)
      ST_BIAS:     return CNT_W'(BIAS_TICKS);
      ST_MC_LOW1:  return CNT_W'(LOW1_TICKS);
      ST_MC_HIGH:  return CNT_W'(HIGH_TICKS);
      ST_MC_LOW2:  return CNT_W'(LOW2_TICKS);
      ST_PLL_WAIT: return CNT_W'(HOLD_TICKS);
      default:     return '0;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_q;
  link_st_e         state_d;

  assign phase_done = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    if (!pd_n || clk_stopped) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:      state_d = ST_BIAS;
        ST_PLL_WAIT: if (phase_done && pll_locked) state_d = ST_STREAM;
        ST_STREAM:   state_d = ST_STREAM;
        default:     if (phase_done) state_d = after_phase(state_q);
      endcase
    end
  end

  assign start_evt = (state_q == ST_OFF) && (state_d == ST_BIAS);

  // one shared down-counter, reloaded on every state entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else if (state_d != state_q) begin
      state_q <= state_d;
      cnt_q   <= phase_len(state_d);
    end else if (pix_tick && !phase_done) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/link_drive_decode.sv
module link_drive_decode
  import link_seq_pkg::*;
(
  input  link_st_e               state_q,
  input  logic                   lane3_q,
  output logic [1:0]             mc_drive,
  output logic [MAX_LANES-1:0]   md_en,
  output logic                   bias_en,
  output logic                   stream_valid
);
  always_comb begin
    mc_drive     = mc_for_state(state_q);
    bias_en      = (state_q != ST_OFF);
    stream_valid = (state_q == ST_STREAM);
    md_en        = stream_valid ? lane_mask(lane3_q) : '0;
  end
endmodule

// File: rtl/link_seq.sv
module link_seq
  import link_seq_pkg::*;
#(
  parameter int BIAS_TICKS = 200,
  parameter int LOW1_TICKS = 200,
  parameter int HIGH_TICKS = 20,
  parameter int LOW2_TICKS = 8,
  parameter int HOLD_TICKS = 600,
  parameter int STOP_LIMIT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pd_n,
  input  logic                 pix_tick,
  input  logic                 lane3_cfg,
  input  logic                 pll_locked,
  output logic [1:0]           mc_drive,
  output logic [MAX_LANES-1:0] md_en,
  output logic                 bias_en,
  output logic                 stream_valid
);
  // named internal events, observed by the bound checker
  link_st_e state_q;
  logic     clk_stopped;
  logic     phase_done;
  logic     start_evt;
  logic     lane3_q;

  link_clk_monitor #(.STOP_LIMIT(STOP_LIMIT)) i_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_tick    (pix_tick),
    .clk_stopped (clk_stopped)
  );

  link_phase_fsm #(
    .BIAS_TICKS (BIAS_TICKS),
    .LOW1_TICKS (LOW1_TICKS),
    .HIGH_TICKS (HIGH_TICKS),
    .LOW2_TICKS (LOW2_TICKS),
    .HOLD_TICKS (HOLD_TICKS)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_n        (pd_n),
    .clk_stopped (clk_stopped),
    .pix_tick    (pix_tick),
    .pll_locked  (pll_locked),
    .state_q     (state_q),
    .phase_done  (phase_done),
    .start_evt   (start_evt)
  );

  // lane setting: sampled at start-up, cleared by power-down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lane3_q <= 1'b0;
    else if (!pd_n)     lane3_q <= 1'b0;
    else if (start_evt) lane3_q <= lane3_cfg;
  end

  link_drive_decode i_dec (
    .state_q      (state_q),
    .lane3_q      (lane3_q),
    .mc_drive     (mc_drive),
    .md_en        (md_en),
    .bias_en      (bias_en),
    .stream_valid (stream_valid)
  );
endmodule

// File: rtl/link_seq_checker.sv
module link_seq_checker
  import link_seq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pd_n,
  input logic                 pix_tick,
  input logic                 pll_locked,
  input logic [1:0]           mc_drive,
  input logic [MAX_LANES-1:0] md_en,
  input logic                 bias_en,
  input logic                 stream_valid,
  input logic                 clk_stopped,
  input logic                 phase_done
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_en |-> (mc_drive == 2'd0 && md_en == '0 && !stream_valid));

  assert_bias_no_current_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_en) |-> mc_drive == 2'd0);

  assert_hold_before_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_valid) |-> $past(mc_drive) == 2'd1);

  assert_pll_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_valid) |-> $past(pll_locked));

  assert_stream_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stream_valid |-> (mc_drive == 2'd3 && (md_en == 3'b011 || md_en == 3'b111)));

  assert_lanes_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_valid && $past(stream_valid)) |-> $stable(md_en));

  assert_pd_forces_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !bias_en);

  assert_stop_forces_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stopped |=> !bias_en);

  assert_phase_change_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_en && $past(bias_en) && !$stable(mc_drive)) |-> $past(phase_done));

  assert_no_tick_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_en && !pix_tick && !phase_done && pd_n && !clk_stopped) |=> $stable(mc_drive));
endmodule

bind link_seq link_seq_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pd_n         (pd_n),
  .pix_tick     (pix_tick),
  .pll_locked   (pll_locked),
  .mc_drive     (mc_drive),
  .md_en        (md_en),
  .bias_en      (bias_en),
  .stream_valid (stream_valid),
  .clk_stopped  (clk_stopped),
  .phase_done   (phase_done)
);

// File: tb/test_link_seq.sv
module test_link_seq;
  localparam int STOP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_n = 1'b0;
  logic       pix_tick = 1'b0;
  logic       lane3_cfg = 1'b0;
  logic       pll_locked = 1'b0;
  logic [1:0] mc_drive;
  logic [2:0] md_en;
  logic       bias_en;
  logic       stream_valid;

  always #10 clk = ~clk;

  link_seq i_link_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_n         (pd_n),
    .pix_tick     (pix_tick),
    .lane3_cfg    (lane3_cfg),
    .pll_locked   (pll_locked),
    .mc_drive     (mc_drive),
    .md_en        (md_en),
    .bias_en      (bias_en),
    .stream_valid (stream_valid)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  function automatic int packed_out();
    return {mc_drive, md_en, bias_en, stream_valid};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // ---------------- reference model (phase index + tick tally) ----------------
  // phase: 0 off, 1 bias, 2 low, 3 high, 4 low, 5 hold-off, 6 streaming
  int len_q[$] = '{0, 200, 200, 20, 8, 600, 0};
  int m_ph = 0, m_ticks = 0, m_idle = STOP;
  bit m_lane = 1'b0, m_stop;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ticks = 0; m_idle = STOP; m_lane = 1'b0;
    end else begin
      m_stop = (m_idle >= STOP);
      if (!pd_n || m_stop) begin
        m_ph = 0; m_ticks = 0;
        if (!pd_n) m_lane = 1'b0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_ticks = 0; m_lane = lane3_cfg;
      end else if (m_ph == 6) begin
        m_ph = 6;
      end else if (m_ticks == len_q[m_ph]) begin
        if (m_ph != 5 || pll_locked) begin m_ph++; m_ticks = 0; end
      end else if (pix_tick) begin
        m_ticks++;
      end
      m_idle = pix_tick ? 0 : ((m_idle < STOP) ? m_idle + 1 : STOP);
    end
  end

  function automatic int exp_out();
    int mc;
    int md;
    case (m_ph)
      2, 4, 5: mc = 1;
      3:       mc = 2;
      6:       mc = 3;
      default: mc = 0;
    endcase
    md = (m_ph == 6) ? (m_lane ? 7 : 3) : 0;
    return (mc << 5) | (md << 2) | ((m_ph != 0) ? 2 : 0) | ((m_ph == 6) ? 1 : 0);
  endfunction

  function automatic string tag_of(input int ph);
    case (ph)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      default: return "R8";
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) chk(packed_out() == exp_out(), tag_of(m_ph), packed_out(), exp_out());
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick_n(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      pix_tick = 1'b1;
      @(negedge clk) pix_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic run_startup(input bit lane, input int gap, input bit pll_ok);
    int want_md;
    want_md = lane ? 7 : 3;
    lane3_cfg = lane; pll_locked = pll_ok;
    tick_n(1, gap);
    chk(bias_en && mc_drive == 2'd0, "R2", packed_out(), 'h02);
    lane3_cfg = !lane;                              // R9: late change must not stick
    tick_n(199, gap);
    chk(bias_en && mc_drive == 2'd0, "R3", packed_out(), 'h02);
    repeat (10) @(negedge clk);                     // R12: no ticks, no progress
    chk(bias_en && mc_drive == 2'd0, "R12", packed_out(), 'h02);
    tick_n(1, gap);
    chk(mc_drive == 2'd1, "R4", mc_drive, 1);
    tick_n(199, gap);
    chk(mc_drive == 2'd1, "R4", mc_drive, 1);
    tick_n(1, gap);
    chk(mc_drive == 2'd2, "R5", mc_drive, 2);
    tick_n(19, gap);
    chk(mc_drive == 2'd2, "R5", mc_drive, 2);
    tick_n(1, gap);
    chk(mc_drive == 2'd1, "R6", mc_drive, 1);
    tick_n(8, gap);
    chk(mc_drive == 2'd1 && !stream_valid, "R6", packed_out(), 'h22);
    tick_n(599, gap);
    chk(mc_drive == 2'd1 && !stream_valid, "R6", packed_out(), 'h22);
    tick_n(1, gap);
    if (pll_ok) begin
      chk(stream_valid && mc_drive == 2'd3, "R8", packed_out(), 'h63 | (want_md << 2));
      chk(md_en == want_md[2:0], "R9", md_en, want_md);
    end else begin
      chk(!stream_valid && mc_drive == 2'd1, "R7", packed_out(), 'h22);
      tick_n(5, gap);
      chk(!stream_valid && mc_drive == 2'd1, "R7", packed_out(), 'h22);
      pll_locked = 1'b1;
      @(negedge clk);
      chk(stream_valid && mc_drive == 2'd3, "R7", packed_out(), 'h63 | (want_md << 2));
      chk(md_en == want_md[2:0], "R9", md_en, want_md);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(packed_out() == 0, "R1", packed_out(), 0);

    // R2: ticks with power-down low, then power-up without a running clock
    tick_n(5, 1);
    chk(!bias_en, "R2", bias_en, 0);
    repeat (20) @(negedge clk);
    pd_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!bias_en && packed_out() == 0, "R2", packed_out(), 0);

    run_startup(1'b0, 1, 1'b1);

    // R11: stopped pixel clock
    tick_n(1, 1);
    repeat (15) @(negedge clk);
    chk(stream_valid, "R11", stream_valid, 1);
    @(negedge clk);
    chk(!bias_en && packed_out() == 0, "R11", packed_out(), 0);

    // R11 restart, R7 late lock, three lanes
    run_startup(1'b1, 3, 1'b0);

    // R10 from streaming
    pd_n = 1'b0;
    @(negedge clk);
    chk(!bias_en && packed_out() == 0, "R10", packed_out(), 0);
    repeat (20) @(negedge clk);
    pd_n = 1'b1;

    // R10 in the middle of the bias phase, ticks keep coming
    lane3_cfg = 1'b0;
    tick_n(1, 1);
    chk(bias_en, "R2", bias_en, 1);
    tick_n(50, 1);
    chk(bias_en && mc_drive == 2'd0, "R3", packed_out(), 'h02);
    pd_n = 1'b0;
    @(negedge clk);
    chk(!bias_en, "R10", bias_en, 0);
    tick_n(3, 1);
    chk(packed_out() == 0, "R10", packed_out(), 0);
    repeat (20) @(negedge clk);
    pd_n = 1'b1;

    run_startup(1'b0, 2, 1'b1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule